// File: doc/BRIEF.md
# Ordered Two-Channel Break Trigger

This block turns the match strobes of two comparator channels, A and B, into a break request for the processor core. It also captures the program-counter value that the exception logic will save. In ordered mode, a break is raised only when channel B hits after channel A has armed the sequence. An optional countdown can hold the break back until a set number of B hits has arrived. In free mode, a hit on either channel raises the request on its own.

Each channel carries a condition type: fetch checked before execution, fetch checked after execution, data address only, or data address plus value. The condition type of the channel that fires decides which of three supplied PC values is stored.

- The fetch-before type stores the address of the matching instruction.
- The fetch-after and address-only types store the address of the following instruction.
- The address-plus-value type is imprecise. It stores the address that follows the last completed instruction.

The comparators and the exception entry sequence sit outside the block.

Top module: `brk_seq_trigger`

## Requirements
- R1: When `seq_mode` is 1 and the sequence is armed, a B hit without an A hit in the same cycle raises `brk_req` for exactly one cycle, starting at the clock edge that samples the hit (subject to R4).
- R2: In ordered mode, a B hit while the sequence is not armed raises no break and does not arm the sequence.
- R3: In ordered mode, a cycle with both A and B hits raises no break and leaves the armed flag and the countdown unchanged.
- R4: With `cnt_on` = 1, an A-only hit loads the countdown from `cnt_load`. A B hit while armed with a countdown above 1 decrements it and raises no break. A B hit with a countdown of 1 or 0 fires. A preload of 0 therefore behaves like 1.
- R5: In ordered mode, an A-only hit while already armed keeps the sequence armed and reloads the countdown from `cnt_load`.
- R6: After any break, the sequence is disarmed. A later B hit alone raises no break until a new A-only hit arms it again.
- R7: When `seq_mode` is 0, any A or B hit raises `brk_req` at the next edge, and the armed flag is cleared.
- R8: Condition codes are 0 for fetch-before, 1 for fetch-after, 2 for data address only and 3 for data address plus value. On a break, `saved_pc` takes the value sampled with the hit, chosen as follows:
  - code 0 takes `pc_fetch`;
  - codes 1 and 2 take `pc_next`;
  - code 3 takes `pc_retired`.
- R9: The condition code used by R8 is chosen as follows:
  - in ordered mode, `cond_b` is used;
  - in free mode, `cond_a` is used whenever A hits, otherwise `cond_b`.
- R10: `saved_pc` changes only in the cycle that `brk_req` rises. It holds its value otherwise.
- R11: Reset (active-low `rst_n`) clears `brk_req`, sets `saved_pc` to 0, and disarms the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seq_mode | input | 1 | 1 = ordered A-then-B, 0 = free per-channel breaks |
| cnt_on | input | 1 | Enables the B-hit countdown in ordered mode |
| cnt_load | input | CNT_W | Countdown preload taken when A arms |
| hit_a | input | 1 | Channel A comparator match strobe |
| hit_b | input | 1 | Channel B comparator match strobe |
| cond_a | input | 2 | Channel A condition code |
| cond_b | input | 2 | Channel B condition code |
| pc_fetch | input | PC_W | Address of the matching instruction |
| pc_next | input | PC_W | Address of the instruction after the matching one |
| pc_retired | input | PC_W | Address after the last completed instruction |
| brk_req | output | 1 | One-cycle break request |
| saved_pc | output | PC_W | PC value to be saved on break entry |

## Verification
Both results are registered once. `brk_req` and `saved_pc` show the outcome of a hit one rising edge after the cycle in which the hit is presented. The armed flag and the countdown take effect on that same edge, so they govern the hit in the following cycle. The bench changes inputs on the falling edge and samples both outputs on the next falling edge, half a cycle after they update. It compares every vector in that window, including the vectors where no request is due, and checks that `saved_pc` has not moved in those cycles.

// File: rtl/brk_pkg.sv
package brk_pkg;

  typedef enum logic [1:0] {
    COND_FETCH_PRE  = 2'd0,
    COND_FETCH_POST = 2'd1,
    COND_DATA_ADDR  = 2'd2,
    COND_DATA_VALUE = 2'd3
  } brk_cond_e;

  typedef enum logic [1:0] {
    SRC_FETCH   = 2'd0,
    SRC_NEXT    = 2'd1,
    SRC_RETIRED = 2'd2
  } pc_src_e;

  // Which supplied PC a condition type stores.
  function automatic pc_src_e src_of_cond(input brk_cond_e c);
    case (c)
      COND_FETCH_PRE:  return SRC_FETCH;
      COND_FETCH_POST: return SRC_NEXT;
      COND_DATA_ADDR:  return SRC_NEXT;
      default:         return SRC_RETIRED;
    endcase
  endfunction

endpackage

// File: rtl/brk_seq_fsm.sv
module brk_seq_fsm
  import brk_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seq_mode,
  input  logic             cnt_on,
  input  logic [CNT_W-1:0] cnt_load,
  input  logic             hit_a,
  input  logic             hit_b,
  input  brk_cond_e        cond_a,
  input  brk_cond_e        cond_b,
  output logic             fire,
  output brk_cond_e        fire_cond,
  output logic             armed,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  // Countdown at its last step: 1, or 0 when preloaded with 0.
  function automatic logic cnt_last(input logic [CNT_W-1:0] v);
    return v <= CNT_ONE;
  endfunction

  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] v);
    return v - CNT_ONE;
  endfunction

  logic both_hit, a_only, b_armed, seq_fire, free_fire, cnt_ok;

  assign both_hit  = hit_a & hit_b;
  assign a_only    = hit_a & ~hit_b;
  assign b_armed   = seq_mode & armed & hit_b & ~hit_a;
  assign cnt_ok    = ~cnt_on | cnt_last(cnt);
  assign seq_fire  = b_armed & cnt_ok;
  assign free_fire = ~seq_mode & (hit_a | hit_b);
  assign fire      = seq_fire | free_fire;
  assign fire_cond = (free_fire && hit_a) ? cond_a : cond_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (!seq_mode) begin
      armed <= 1'b0;
    end else if (both_hit) begin
      armed <= armed;
    end else if (a_only) begin
      armed <= 1'b1;
      cnt   <= cnt_load;
    end else if (b_armed) begin
      if (seq_fire) armed <= 1'b0;
      else          cnt   <= cnt_step(cnt);
    end
  end

  p_disarm_after_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !armed);

  p_arm_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_mode && hit_a && !hit_b) |=> (armed && cnt == $past(cnt_load)));

  p_simul_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_mode && hit_a && hit_b) |=> ($stable(armed) && $stable(cnt)));

  p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_mode && cnt_on && armed && hit_b && !hit_a && cnt > CNT_ONE)
      |=> (armed && cnt == $past(cnt) - CNT_ONE));

  p_unarmed_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_mode && !armed && hit_b && !hit_a) |=> !armed);

endmodule

// File: rtl/brk_pc_pick.sv
module brk_pc_pick
  import brk_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire,
  input  brk_cond_e       fire_cond,
  input  logic [PC_W-1:0] pc_fetch,
  input  logic [PC_W-1:0] pc_next,
  input  logic [PC_W-1:0] pc_retired,
  output logic            brk_req,
  output logic [PC_W-1:0] saved_pc
);

  function automatic logic [PC_W-1:0] pick_pc(
    input brk_cond_e       c,
    input logic [PC_W-1:0] f,
    input logic [PC_W-1:0] n,
    input logic [PC_W-1:0] r
  );
    case (src_of_cond(c))
      SRC_FETCH: return f;
      SRC_NEXT:  return n;
      default:   return r;
    endcase
  endfunction

  logic [PC_W-1:0] pc_sel;
  assign pc_sel = pick_pc(fire_cond, pc_fetch, pc_next, pc_retired);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_req  <= 1'b0;
      saved_pc <= '0;
    end else begin
      brk_req <= fire;
      if (fire) saved_pc <= pc_sel;
    end
  end

  p_req_follows_fire_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> brk_req);

  p_pc_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(saved_pc));

  p_pc_fetch_pre_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && fire_cond == COND_FETCH_PRE) |=> saved_pc == $past(pc_fetch));

  p_pc_imprecise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && fire_cond == COND_DATA_VALUE) |=> saved_pc == $past(pc_retired));

endmodule

// File: rtl/brk_seq_trigger.sv
module brk_seq_trigger
  import brk_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PC_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seq_mode,
  input  logic             cnt_on,
  input  logic [CNT_W-1:0] cnt_load,
  input  logic             hit_a,
  input  logic             hit_b,
  input  logic [1:0]       cond_a,
  input  logic [1:0]       cond_b,
  input  logic [PC_W-1:0]  pc_fetch,
  input  logic [PC_W-1:0]  pc_next,
  input  logic [PC_W-1:0]  pc_retired,
  output logic             brk_req,
  output logic [PC_W-1:0]  saved_pc
);

  logic             fire;
  brk_cond_e        fire_cond;
  logic             armed;
  logic [CNT_W-1:0] cnt;

  brk_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .seq_mode (seq_mode),
    .cnt_on   (cnt_on),
    .cnt_load (cnt_load),
    .hit_a    (hit_a),
    .hit_b    (hit_b),
    .cond_a   (brk_cond_e'(cond_a)),
    .cond_b   (brk_cond_e'(cond_b)),
    .fire     (fire),
    .fire_cond(fire_cond),
    .armed    (armed),
    .cnt      (cnt)
  );

  brk_pc_pick #(.PC_W(PC_W)) u_pick (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .fire_cond (fire_cond),
    .pc_fetch  (pc_fetch),
    .pc_next   (pc_next),
    .pc_retired(pc_retired),
    .brk_req   (brk_req),
    .saved_pc  (saved_pc)
  );

  p_b_before_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_mode && !armed && hit_b) |=> !brk_req);

  p_simul_no_break_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_mode && hit_a && hit_b) |=> !brk_req);

  p_free_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_mode && (hit_a || hit_b)) |=> brk_req);

  p_quiet_no_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_a && !hit_b) |=> !brk_req);

  p_ordered_uses_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_mode && fire) |-> fire_cond == brk_cond_e'(cond_b));

endmodule

// File: tb/sim_brk_seq_trigger.sv
module sim_brk_seq_trigger;
  localparam int CNT_W = 8;
  localparam int PC_W  = 16;
  localparam int NVEC  = 27;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             seq_mode = 1'b0, cnt_on = 1'b0, hit_a = 1'b0, hit_b = 1'b0;
  logic [CNT_W-1:0] cnt_load = '0;
  logic [1:0]       cond_a = '0, cond_b = '0;
  logic [PC_W-1:0]  pc_fetch = '0, pc_next = '0, pc_retired = '0;
  logic             brk_req;
  logic [PC_W-1:0]  saved_pc;

  int checks = 0, failures = 0, cycles = 0;

  always #5 clk = ~clk;

  brk_seq_trigger #(.CNT_W(CNT_W), .PC_W(PC_W)) u0 (.*);

  // src: 0 hold, 1 matching address, 2 following address, 3 after last retired
  typedef struct packed {
    logic       seq;
    logic       ce;
    logic [7:0] pre;
    logic       ma;
    logic       mb;
    logic [1:0] ca;
    logic [1:0] cb;
    logic       req;
    logic [1:0] src;
    logic [3:0] rq;
  } vec_t;

  localparam vec_t VEC [NVEC] = '{
    '{1'b1,1'b0,8'd0,1'b0,1'b1,2'd0,2'd0,1'b0,2'd0,4'd2},  // 0  R2 B before A
    '{1'b1,1'b0,8'd0,1'b1,1'b1,2'd0,2'd0,1'b0,2'd0,4'd3},  // 1  R3 both while idle
    '{1'b1,1'b0,8'd0,1'b0,1'b1,2'd0,2'd0,1'b0,2'd0,4'd3},  // 2  R3 still not armed
    '{1'b1,1'b0,8'd0,1'b1,1'b0,2'd0,2'd0,1'b0,2'd0,4'd1},  // 3  R1 arm
    '{1'b1,1'b0,8'd0,1'b0,1'b1,2'd1,2'd0,1'b1,2'd1,4'd1},  // 4  R1 R8 fetch-before
    '{1'b1,1'b0,8'd0,1'b0,1'b1,2'd0,2'd0,1'b0,2'd0,4'd6},  // 5  R6 disarmed
    '{1'b1,1'b0,8'd0,1'b1,1'b0,2'd0,2'd0,1'b0,2'd0,4'd1},  // 6  arm
    '{1'b1,1'b0,8'd0,1'b1,1'b1,2'd0,2'd0,1'b0,2'd0,4'd3},  // 7  R3 both while armed
    '{1'b1,1'b0,8'd0,1'b0,1'b1,2'd3,2'd1,1'b1,2'd2,4'd9},  // 8  R9 R8 fetch-after uses B
    '{1'b1,1'b0,8'd0,1'b0,1'b0,2'd0,2'd0,1'b0,2'd0,4'd10}, // 9  R10 hold
    '{1'b1,1'b1,8'd3,1'b1,1'b0,2'd0,2'd0,1'b0,2'd0,4'd4},  // 10 R4 arm count 3
    '{1'b1,1'b1,8'd3,1'b0,1'b1,2'd0,2'd2,1'b0,2'd0,4'd4},  // 11 count 2
    '{1'b1,1'b1,8'd3,1'b0,1'b1,2'd0,2'd2,1'b0,2'd0,4'd4},  // 12 count 1
    '{1'b1,1'b1,8'd3,1'b0,1'b1,2'd0,2'd2,1'b1,2'd2,4'd4},  // 13 R4 fire, data address
    '{1'b1,1'b1,8'd3,1'b1,1'b0,2'd0,2'd0,1'b0,2'd0,4'd5},  // 14 arm count 3
    '{1'b1,1'b1,8'd3,1'b0,1'b1,2'd0,2'd0,1'b0,2'd0,4'd5},  // 15 count 2
    '{1'b1,1'b1,8'd3,1'b1,1'b0,2'd0,2'd0,1'b0,2'd0,4'd5},  // 16 R5 re-arm reload 3
    '{1'b1,1'b1,8'd3,1'b0,1'b1,2'd0,2'd0,1'b0,2'd0,4'd5},  // 17 count 2
    '{1'b1,1'b1,8'd3,1'b0,1'b1,2'd0,2'd0,1'b0,2'd0,4'd5},  // 18 count 1
    '{1'b1,1'b1,8'd3,1'b0,1'b1,2'd0,2'd3,1'b1,2'd3,4'd5},  // 19 R5 R8 imprecise
    '{1'b1,1'b1,8'd0,1'b1,1'b0,2'd0,2'd0,1'b0,2'd0,4'd4},  // 20 arm preload 0
    '{1'b1,1'b1,8'd0,1'b0,1'b1,2'd0,2'd0,1'b1,2'd1,4'd4},  // 21 R4 preload 0 fires
    '{1'b0,1'b0,8'd0,1'b1,1'b0,2'd3,2'd0,1'b1,2'd3,4'd7},  // 22 R7 free A
    '{1'b0,1'b0,8'd0,1'b0,1'b1,2'd0,2'd1,1'b1,2'd2,4'd7},  // 23 R7 free B
    '{1'b0,1'b0,8'd0,1'b1,1'b1,2'd0,2'd2,1'b1,2'd1,4'd9},  // 24 R9 A wins in free mode
    '{1'b0,1'b0,8'd0,1'b0,1'b0,2'd0,2'd0,1'b0,2'd0,4'd10}, // 25 R10 hold
    '{1'b1,1'b0,8'd0,1'b0,1'b1,2'd0,2'd0,1'b0,2'd0,4'd7}   // 26 R7 free mode disarmed
  };

  function automatic logic [PC_W-1:0] base_of(input int idx);
    return PC_W'(16'h1000 + idx * 16);
  endfunction

  function automatic logic [PC_W-1:0] exp_of(input logic [1:0] src, input int idx,
                                             input logic [PC_W-1:0] prev);
    case (src)
      2'd1:    return base_of(idx);
      2'd2:    return base_of(idx) + 2;
      2'd3:    return base_of(idx) + 6;
      default: return prev;
    endcase
  endfunction

  task automatic set_pcs(input int idx);
    pc_fetch   = base_of(idx);
    pc_next    = base_of(idx) + 2;
    pc_retired = base_of(idx) + 6;
  endtask

  task automatic check(input string tag, input logic req_exp, input logic [PC_W-1:0] pc_exp);
    checks++;
    if (brk_req !== req_exp || saved_pc !== pc_exp) begin
      failures++;
      $display("FAIL %s brk_req=%0b/%0h expected %0b/%0h", tag, brk_req, saved_pc,
               req_exp, pc_exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic s, input logic ce, input logic [7:0] pre,
                       input logic a, input logic b, input logic [1:0] ca,
                       input logic [1:0] cb);
    seq_mode = s; cnt_on = ce; cnt_load = pre;
    hit_a = a; hit_b = b; cond_a = ca; cond_b = cb;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000) begin
        failures++;
        $display("FAIL watchdog cycles=%0d expected below 5000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    logic [PC_W-1:0] exp_pc;
    exp_pc = '0;
    @(negedge clk);
    step();
    check("R11 reset state", 1'b0, '0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i].seq, VEC[i].ce, VEC[i].pre, VEC[i].ma, VEC[i].mb, VEC[i].ca, VEC[i].cb);
      set_pcs(i);
      step();
      exp_pc = exp_of(VEC[i].src, i, exp_pc);
      check($sformatf("R%0d vector %0d", VEC[i].rq, i), VEC[i].req, exp_pc);
    end

    // R4: long countdown fires on exactly the fifth B hit
    drive(1'b1, 1'b1, 8'd5, 1'b1, 1'b0, 2'd0, 2'd0);
    set_pcs(40);
    step();
    check("R4 arm for count 5", 1'b0, exp_pc);
    for (int k = 1; k <= 5; k++) begin
      drive(1'b1, 1'b1, 8'd5, 1'b0, 1'b1, 2'd0, 2'd1);
      set_pcs(40 + k);
      step();
      if (k == 5) exp_pc = base_of(40 + k) + 2;
      check($sformatf("R4 B hit %0d of 5", k), k == 5, exp_pc);
    end

    // R11: reset while armed disarms and clears outputs
    drive(1'b1, 1'b0, 8'd0, 1'b1, 1'b0, 2'd0, 2'd0);
    step();
    drive(1'b1, 1'b0, 8'd0, 1'b0, 1'b0, 2'd0, 2'd0);
    rst_n = 1'b0;
    step();
    check("R11 reset clears pc", 1'b0, '0);
    rst_n = 1'b1;
    drive(1'b1, 1'b0, 8'd0, 1'b0, 1'b1, 2'd0, 2'd0);
    set_pcs(60);
    step();
    check("R11 disarmed after reset", 1'b0, '0);
    drive(1'b1, 1'b0, 8'd0, 1'b0, 1'b0, 2'd0, 2'd0);
    step();
    check("R1 no hit no request", 1'b0, '0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule